// File: doc/BRIEF.md
# Wormhole Input Request Controller

This block sits at one input port of an N-by-N wormhole packet switch. Every cycle it looks at the flit waiting at the head of the input buffer and decides which output arbiter, if any, should see a request from this input. A head flit names its output through a binary destination field. The block asks for that output only when the output is unclaimed and its downstream buffer can take a flit. Body and tail flits follow the output that the head flit claimed. The block keeps that output as a one-hot route record, and these flits need only the downstream ready signal.

The output arbiters return one grant bit each. The block ORs these bits into a single take strobe, which pops the flit from the input buffer. The same strobe drives a two-state machine. In state IDLE no packet is bound to an output. In state BOUND the route record holds the claimed output. Transition CLAIM (IDLE to BOUND) fires on a granted head flit that is not also a tail. Transition RELEASE (BOUND to IDLE) fires on a granted tail flit. Transition PASS keeps the state unchanged on any other cycle, including a granted single-flit packet in IDLE.

Top module: `wh_input_ctrl`

## Requirements
- R1: After synchronous active-high reset, `route_q` is all zeros and `pkt_bound` is 0. While the record is zero, a non-head flit raises no request line.
- R2: For a head flit (`flit_head`=1) with `flit_valid`=1, `req` is the one-hot code with bit `flit_dst` set when `out_free[flit_dst]`=1 and `out_ready[flit_dst]`=1. Otherwise `req` is zero.
- R3: For a head flit whose output is taken (`out_free[flit_dst]`=0), `req` is zero whatever the ready signals are.
- R4: For a non-head flit with `flit_valid`=1, `req` equals `route_q & out_ready`. `out_free` has no effect on it.
- R5: At most one bit of `req` is set, and no bit is set while `flit_valid`=0.
- R6: `flit_take` is the OR of all bits of `gnt`.
- R7: On a cycle with `flit_take`=1, `flit_head`=1 and `flit_tail`=0 (CLAIM), the next cycle shows `route_q` equal to the one-hot code of `flit_dst` and `pkt_bound`=1.
- R8: On a cycle with `flit_take`=1 and `flit_tail`=1 while the packet is bound (RELEASE), the next cycle shows `route_q`=0 and `pkt_bound`=0.
- R9: A granted flit with both `flit_head` and `flit_tail` set in IDLE leaves `route_q` at zero and `pkt_bound` at 0.
- R10: On a cycle with `flit_take`=0, `route_q` and `pkt_bound` keep their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flit_valid | input | 1 | A flit is waiting at this input |
| flit_head | input | 1 | Flit is the first of its packet |
| flit_tail | input | 1 | Flit is the last of its packet |
| flit_dst | input | $clog2(NUM_PORTS) | Binary output number carried by a head flit |
| out_free | input | NUM_PORTS | Per output: 1 when no input has claimed it |
| out_ready | input | NUM_PORTS | Per output: 1 when its downstream buffer has room |
| req | output | NUM_PORTS | One-hot request toward the output arbiters |
| gnt | input | NUM_PORTS | Grant bits returned by the output arbiters |
| flit_take | output | 1 | Merged grant; dequeues the flit |
| route_q | output | NUM_PORTS | One-hot record of the output bound to the packet |
| pkt_bound | output | 1 | 1 in state BOUND |

## Verification
Head flits are swept over every destination and every combination of the free and ready vectors, with the valid bit both low and high. This separates the availability mask from the ready mask and shows that only the addressed bit of each vector counts. Non-head flits get the same free and ready sweeps, first with an empty record and then with a record bound to each output. These sweeps show that availability is ignored once an output is claimed and that nothing is requested without a record. Grant patterns are swept for the OR merge. CLAIM, RELEASE, single-flit packets and ungranted cycles are run for every output to cover the record's write, clear and hold paths.

// File: rtl/wh_pkg.sv
package wh_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BOUND = 1'b1
    } wh_state_e;
endpackage

// File: rtl/wh_dst_decode.sv
module wh_dst_decode #(
    parameter int NUM_PORTS = 4,
    localparam int DST_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic [DST_W-1:0]     dst,
    output logic [NUM_PORTS-1:0] onehot
);
    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_dec
        assign onehot[i] = (dst == DST_W'(i));
    end
endmodule

// File: rtl/wh_req_qualify.sv
module wh_req_qualify #(
    parameter int NUM_PORTS = 4
) (
    input  logic                 valid,
    input  logic                 head,
    input  logic [NUM_PORTS-1:0] dec,
    input  logic [NUM_PORTS-1:0] route,
    input  logic [NUM_PORTS-1:0] free,
    input  logic [NUM_PORTS-1:0] ready,
    output logic [NUM_PORTS-1:0] sel,
    output logic [NUM_PORTS-1:0] req
);
    logic avail_ok;

    always_comb begin
        sel      = head ? dec : route;
        // continuation flits already own their output
        avail_ok = head ? |(sel & free) : 1'b1;
        req      = (valid && avail_ok) ? (sel & ready) : '0;
    end
endmodule

// File: rtl/wh_route_fsm.sv
module wh_route_fsm
    import wh_pkg::*;
#(
    parameter int NUM_PORTS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 take,
    input  logic                 head,
    input  logic                 tail,
    input  logic [NUM_PORTS-1:0] sel,
    output logic [NUM_PORTS-1:0] route_q,
    output logic                 bound
);
    wh_state_e            state_q, state_n;
    logic [NUM_PORTS-1:0] route_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            route_q <= '0;
        end else begin
            state_q <= state_n;
            route_q <= route_n;
        end
    end

    always_comb begin
        state_n = state_q;
        route_n = route_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take && head && !tail) begin   // CLAIM
                    state_n = ST_BOUND;
                    route_n = sel;
                end
            end
            ST_BOUND: begin
                if (take && tail) begin            // RELEASE
                    state_n = ST_IDLE;
                    route_n = '0;
                end else if (take && head) begin
                    route_n = sel;
                end
            end
            default: begin
                state_n = ST_IDLE;
                route_n = '0;
            end
        endcase
    end

    assign bound = (state_q == ST_BOUND);

    AST_ROUTE_ONEHOT0: assert property (@(posedge clk) disable iff (rst)
        $onehot0(route_q)); // R7
    AST_HOLD_NO_TAKE: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(route_q) && $stable(state_q)); // R10
    AST_RELEASE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (take && tail && state_q == ST_BOUND) |=> (route_q == '0) && !bound); // R8
    AST_SINGLE_FLIT: assert property (@(posedge clk) disable iff (rst)
        (take && head && tail && state_q == ST_IDLE) |=> (route_q == '0)); // R9
endmodule

// File: rtl/wh_input_ctrl.sv
module wh_input_ctrl #(
    parameter int NUM_PORTS = 4,
    localparam int DST_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flit_valid,
    input  logic                 flit_head,
    input  logic                 flit_tail,
    input  logic [DST_W-1:0]     flit_dst,
    input  logic [NUM_PORTS-1:0] out_free,
    input  logic [NUM_PORTS-1:0] out_ready,
    output logic [NUM_PORTS-1:0] req,
    input  logic [NUM_PORTS-1:0] gnt,
    output logic                 flit_take,
    output logic [NUM_PORTS-1:0] route_q,
    output logic                 pkt_bound
);
    logic [NUM_PORTS-1:0] dec;
    logic [NUM_PORTS-1:0] sel;

    wh_dst_decode #(.NUM_PORTS(NUM_PORTS)) u_dec (
        .dst    (flit_dst),
        .onehot (dec)
    );

    wh_req_qualify #(.NUM_PORTS(NUM_PORTS)) u_qual (
        .valid (flit_valid),
        .head  (flit_head),
        .dec   (dec),
        .route (route_q),
        .free  (out_free),
        .ready (out_ready),
        .sel   (sel),
        .req   (req)
    );

    assign flit_take = |gnt;

    wh_route_fsm #(.NUM_PORTS(NUM_PORTS)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .take    (flit_take),
        .head    (flit_head),
        .tail    (flit_tail),
        .sel     (sel),
        .route_q (route_q),
        .bound   (pkt_bound)
    );

    AST_REQ_ONEHOT0: assert property (@(posedge clk) disable iff (rst)
        $onehot0(req)); // R5
    AST_REQ_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        !flit_valid |-> (req == '0)); // R5
    AST_HEAD_TAKEN_SILENT: assert property (@(posedge clk) disable iff (rst)
        (flit_head && (out_free & dec) == '0) |-> (req == '0)); // R3
    AST_BODY_FOLLOWS_ROUTE: assert property (@(posedge clk) disable iff (rst)
        (!flit_head && flit_valid) |-> (req == (route_q & out_ready))); // R4
    AST_CLAIM_RECORD: assert property (@(posedge clk) disable iff (rst)
        (flit_take && flit_head && !flit_tail) |=> (route_q == $past(dec)) && pkt_bound); // R7
endmodule

// File: tb/wh_input_ctrl_tb_top.sv
module wh_input_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int DW = 2;

    logic          clk = 1'b0;
    logic          rst;
    logic          flit_valid, flit_head, flit_tail;
    logic [DW-1:0] flit_dst;
    logic [N-1:0]  out_free, out_ready, gnt;
    logic [N-1:0]  req, route_q;
    logic          flit_take, pkt_bound;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wh_input_ctrl #(.NUM_PORTS(N)) dut_i (
        .clk(clk), .rst(rst), .flit_valid(flit_valid), .flit_head(flit_head),
        .flit_tail(flit_tail), .flit_dst(flit_dst), .out_free(out_free),
        .out_ready(out_ready), .req(req), .gnt(gnt), .flit_take(flit_take),
        .route_q(route_q), .pkt_bound(pkt_bound)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        flit_valid = 0; flit_head = 0; flit_tail = 0; flit_dst = '0;
        out_free = '0; out_ready = '0; gnt = '0;
    endtask

    // grant one flit on output d at a posedge, then look at the record
    task automatic grant_flit(input logic hd, input logic tl, input int d);
        @(negedge clk);
        flit_valid = 1; flit_head = hd; flit_tail = tl; flit_dst = DW'(d);
        out_free = '1; out_ready = '1; gnt = N'(1 << d);
        @(posedge clk); #1;
        idle_inputs();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle_inputs();
        rst = 1;
        repeat (2) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        chk("R1 route after reset", 8'(route_q), 8'h0);
        chk("R1 bound after reset", 8'(pkt_bound), 8'h0);

        // R1/R4: body flit with empty record, full sweep
        for (int f = 0; f < 16; f++)
            for (int r = 0; r < 16; r++) begin
                @(negedge clk);
                flit_valid = 1; flit_head = 0; flit_tail = f[0];
                out_free = N'(f); out_ready = N'(r); #1;
                chk("R1 no record no req", 8'(req), 8'h0);
            end

        // R2/R3/R5: head sweep
        for (int d = 0; d < N; d++)
            for (int f = 0; f < 16; f++)
                for (int r = 0; r < 16; r++)
                    for (int v = 0; v < 2; v++) begin
                        logic [N-1:0] e;
                        @(negedge clk);
                        flit_valid = v[0]; flit_head = 1; flit_tail = 0;
                        flit_dst = DW'(d); out_free = N'(f); out_ready = N'(r); #1;
                        e = (v == 1 && f[d] && r[d]) ? N'(1 << d) : '0;
                        if (!f[d]) chk("R3 taken output silent", 8'(req), 8'h0);
                        else if (v == 0) chk("R5 no valid no req", 8'(req), 8'h0);
                        else chk("R2 head request", 8'(req), 8'(e));
                    end

        // R6: merge
        idle_inputs();
        for (int g = 0; g < 16; g++) begin
            @(negedge clk); gnt = N'(g); #1;
            chk("R6 merged grant", 8'(flit_take), 8'(g != 0));
        end
        gnt = '0;

        for (int d = 0; d < N; d++) begin
            // R10: ungranted head leaves record
            @(negedge clk);
            flit_valid = 1; flit_head = 1; flit_dst = DW'(d); out_free = '1; out_ready = '1;
            @(posedge clk); #1;
            chk("R10 hold without grant", 8'(route_q), 8'h0);
            idle_inputs();
            // R7: claim
            grant_flit(1, 0, d);
            chk("R7 record set", 8'(route_q), 8'(1 << d));
            chk("R7 bound", 8'(pkt_bound), 8'h1);
            // R4: body sweep with bound record
            for (int f = 0; f < 16; f++)
                for (int r = 0; r < 16; r++) begin
                    @(negedge clk);
                    flit_valid = 1; flit_head = 0; flit_tail = 0;
                    flit_dst = DW'(d + 1); out_free = N'(f); out_ready = N'(r); #1;
                    chk("R4 body request", 8'(req), 8'(r[d] ? (1 << d) : 0));
                end
            idle_inputs();
            // R10: idle cycle keeps record
            @(posedge clk); #1;
            chk("R10 record held", 8'(route_q), 8'(1 << d));
            grant_flit(0, 0, d);
            chk("R4 body grant keeps record", 8'(route_q), 8'(1 << d));
            // R8: release
            grant_flit(0, 1, d);
            chk("R8 record cleared", 8'(route_q), 8'h0);
            chk("R8 unbound", 8'(pkt_bound), 8'h0);
            // R9: single-flit packet
            grant_flit(1, 1, d);
            chk("R9 single flit record", 8'(route_q), 8'h0);
            chk("R9 single flit unbound", 8'(pkt_bound), 8'h0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule